// File: doc/BRIEF.md
# Thread Block Dispatcher

This block takes the thread blocks of one kernel launch, one request at a time, and places each on one of a parameterised number of multiprocessors. Each request carries a block identifier and a thread count. For every multiprocessor the dispatcher keeps three running totals: resident blocks, resident threads and resident warps. A block is placed only on a multiprocessor where all three totals stay within their caps after the block is added. A warp holds 32 threads, so a block needs the thread count divided by 32, rounded up, warps.

Blocks leave the queue strictly in arrival order. If the block at the head fits on no multiprocessor, it waits, and the blocks behind it wait too. When a multiprocessor finishes a block, it reports the released thread and warp counts on its completion input. The dispatcher subtracts them, and subtracts one block, so that waiting work can be placed. A request with a thread count the hardware cannot hold is taken off the queue and flagged, and nothing is launched for it.

Top module: `tbd_dispatch`

## Requirements
- R1: After reset every multiprocessor is empty and no launch output is active. A valid request of any legal size is accepted at once and launched on multiprocessor 0.
- R2: A launch reports the block's warp count, which is the thread count divided by 32 and rounded up: 1 and 32 threads give 1 warp, 33 give 2, and 512 give 16.
- R3: A thread count of 0, or any count above 512, is accepted in the same cycle with `req_error` high. Nothing is launched for it, and no occupancy changes.
- R4: A multiprocessor never holds more than 8 resident blocks. A ninth block goes to another multiprocessor.
- R5: A multiprocessor never holds more than 768 resident threads.
- R6: A multiprocessor never holds more than 24 resident warps, even when its thread total is still below 768. For example, six 97-thread blocks use 24 warps, so a seventh 97-thread block goes elsewhere.
- R7: Among the multiprocessors that can take the head block, the one with the lowest index is chosen.
- R8: While the head block fits on no multiprocessor, `req_ready` stays low and nothing is launched. Later blocks never overtake it.
- R9: A completion pulse frees one block plus the thread and warp counts it carries. The head block can be accepted in the next cycle. A completion and a launch on the same multiprocessor in the same cycle both take effect.
- R10: At most one launch per cycle. The launch appears on the chosen multiprocessor's outputs in the cycle after the request is accepted, as a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Head block request present |
| req_ready | output | 1 | Head block is accepted this cycle |
| req_id | input | ID_W | Block identifier |
| req_threads | input | THR_W | Threads in the block |
| req_error | output | 1 | Accepted request had an illegal thread count and was dropped |
| launch_valid | output | NUM_MP | One-cycle launch pulse per multiprocessor |
| launch_id | output | NUM_MP*ID_W | Identifier of the launched block, per multiprocessor |
| launch_warps | output | NUM_MP*WARP_W | Warp count of the launched block, per multiprocessor |
| done_valid | input | NUM_MP | Completion pulse per multiprocessor |
| done_threads | input | NUM_MP*THR_W | Threads released by the completion |
| done_warps | input | NUM_MP*WARP_W | Warps released by the completion |

## Verification
The bench drives request streams built so that each one hits a single cap first. Many one-thread blocks reach the block cap. Pairs of 512-thread blocks reach the thread cap. Runs of 97-thread blocks reach the warp cap while the thread total is still low. Each stream shows which multiprocessor was chosen, which in turn shows which cap was enforced. Thread counts of 1, 32, 33 and 512 separate correct rounding from truncation. A stalled head block released by a completion shows both in-order blocking and resource return. A launch in the same cycle as a completion on the same multiprocessor, followed by probe blocks, shows whether either update was lost.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

   // Integer division rounded toward positive infinity.
   function automatic logic [31:0] ceil_div(input logic [31:0] num, input logic [31:0] den);
      return (num + den - 32'd1) / den;
   endfunction

endpackage

// File: rtl/tbd_lowest_pick.sv
module tbd_lowest_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] cand,
   output logic [N-1:0] pick
);
   always_comb begin
      logic taken;
      taken = 1'b0;
      pick  = '0;
      for (int i = 0; i < N; i++) begin
         if (cand[i] && !taken) begin
            pick[i] = 1'b1;
            taken   = 1'b1;
         end
      end
   end
endmodule

// File: rtl/tbd_mp_slot.sv
module tbd_mp_slot #(
   parameter int ID_W     = 8,
   parameter int MAX_BLK  = 8,
   parameter int MAX_THR  = 768,
   parameter int MAX_WRP  = 24,
   parameter int THR_W    = 10,
   parameter int WARP_W   = 5,
   parameter int BLK_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [THR_W-1:0]  cand_threads,
   input  logic [WARP_W-1:0] cand_warps,
   input  logic [ID_W-1:0]   cand_id,
   input  logic              admit,
   input  logic              rel,
   input  logic [THR_W-1:0]  rel_threads,
   input  logic [WARP_W-1:0] rel_warps,
   output logic              fits,
   output logic              out_valid,
   output logic [ID_W-1:0]   out_id,
   output logic [WARP_W-1:0] out_warps,
   output logic [BLK_W-1:0]  blk_occ,
   output logic [THR_W-1:0]  thr_occ,
   output logic [WARP_W-1:0] wrp_occ
);
   logic [THR_W:0]  thr_sum;
   logic [WARP_W:0] wrp_sum;

   assign thr_sum = {1'b0, thr_occ} + {1'b0, cand_threads};
   assign wrp_sum = {1'b0, wrp_occ} + {1'b0, cand_warps};

   assign fits = (blk_occ < BLK_W'(MAX_BLK))
              && (thr_sum <= (THR_W+1)'(MAX_THR))
              && (wrp_sum <= (WARP_W+1)'(MAX_WRP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_occ   <= '0;
         thr_occ   <= '0;
         wrp_occ   <= '0;
         out_valid <= 1'b0;
         out_id    <= '0;
         out_warps <= '0;
      end else begin
         blk_occ   <= blk_occ + BLK_W'(admit) - BLK_W'(rel);
         thr_occ   <= thr_occ + (admit ? cand_threads : '0) - (rel ? rel_threads : '0);
         wrp_occ   <= wrp_occ + (admit ? cand_warps : '0) - (rel ? rel_warps : '0);
         out_valid <= admit;
         if (admit) begin
            out_id    <= cand_id;
            out_warps <= cand_warps;
         end
      end
   end
endmodule

// File: rtl/tbd_dispatch.sv
module tbd_dispatch #(
   parameter int NUM_MP          = 4,
   parameter int ID_W            = 8,
   parameter int WARP_SIZE       = 32,
   parameter int MAX_BLK_THREADS = 512,
   parameter int MP_MAX_BLOCKS   = 8,
   parameter int MP_MAX_THREADS  = 768,
   localparam int MP_MAX_WARPS   = MP_MAX_THREADS / WARP_SIZE,
   localparam int THR_W          = $clog2(MP_MAX_THREADS + 1),
   localparam int WARP_W         = $clog2(MP_MAX_WARPS + 1),
   localparam int BLK_W          = $clog2(MP_MAX_BLOCKS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [ID_W-1:0]          req_id,
   input  logic [THR_W-1:0]         req_threads,
   output logic                     req_error,
   output logic [NUM_MP-1:0]        launch_valid,
   output logic [NUM_MP*ID_W-1:0]   launch_id,
   output logic [NUM_MP*WARP_W-1:0] launch_warps,
   input  logic [NUM_MP-1:0]        done_valid,
   input  logic [NUM_MP*THR_W-1:0]  done_threads,
   input  logic [NUM_MP*WARP_W-1:0] done_warps
);
   if (NUM_MP < 1) begin : g_bad_mp
      $error("NUM_MP must be at least 1");
   end
   if (MP_MAX_THREADS % WARP_SIZE != 0) begin : g_bad_warp
      $error("MP_MAX_THREADS must be a whole number of warps");
   end
   if (MAX_BLK_THREADS > MP_MAX_THREADS) begin : g_bad_blk
      $error("a legal block must fit on an empty multiprocessor");
   end

   logic                     head_bad;
   logic [WARP_W-1:0]        head_warps;
   logic [NUM_MP-1:0]        mp_fits;
   logic [NUM_MP-1:0]        mp_grant;
   logic                     admit;
   logic [NUM_MP*BLK_W-1:0]  blk_occ;
   logic [NUM_MP*THR_W-1:0]  thr_occ;
   logic [NUM_MP*WARP_W-1:0] wrp_occ;

   assign head_bad   = (req_threads == '0) || (req_threads > THR_W'(MAX_BLK_THREADS));
   assign head_warps = WARP_W'(tbd_pkg::ceil_div(32'(req_threads), WARP_SIZE));
   assign req_ready  = head_bad || (|mp_fits);
   assign req_error  = req_valid && head_bad;
   assign admit      = req_valid && !head_bad && (|mp_fits);

   logic [NUM_MP-1:0] pick_raw;
   tbd_lowest_pick #(.N(NUM_MP)) i_pick (
      .cand (mp_fits),
      .pick (pick_raw)
   );
   assign mp_grant = admit ? pick_raw : '0;

   for (genvar g = 0; g < NUM_MP; g++) begin : g_mp
      tbd_mp_slot #(
         .ID_W    (ID_W),
         .MAX_BLK (MP_MAX_BLOCKS),
         .MAX_THR (MP_MAX_THREADS),
         .MAX_WRP (MP_MAX_WARPS),
         .THR_W   (THR_W),
         .WARP_W  (WARP_W),
         .BLK_W   (BLK_W)
      ) i_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .cand_threads (req_threads),
         .cand_warps   (head_warps),
         .cand_id      (req_id),
         .admit        (mp_grant[g]),
         .rel          (done_valid[g]),
         .rel_threads  (done_threads[g*THR_W +: THR_W]),
         .rel_warps    (done_warps[g*WARP_W +: WARP_W]),
         .fits         (mp_fits[g]),
         .out_valid    (launch_valid[g]),
         .out_id       (launch_id[g*ID_W +: ID_W]),
         .out_warps    (launch_warps[g*WARP_W +: WARP_W]),
         .blk_occ      (blk_occ[g*BLK_W +: BLK_W]),
         .thr_occ      (thr_occ[g*THR_W +: THR_W]),
         .wrp_occ      (wrp_occ[g*WARP_W +: WARP_W])
      );
   end
endmodule

// File: rtl/tbd_dispatch_chk.sv
module tbd_dispatch_chk #(
   parameter int NUM_MP          = 4,
   parameter int WARP_SIZE       = 32,
   parameter int MAX_BLK_THREADS = 512,
   parameter int MP_MAX_BLOCKS   = 8,
   parameter int MP_MAX_THREADS  = 768,
   parameter int THR_W           = 10,
   parameter int WARP_W          = 5,
   parameter int BLK_W           = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic                     req_ready,
   input logic [THR_W-1:0]         req_threads,
   input logic                     req_error,
   input logic [NUM_MP-1:0]        launch_valid,
   input logic [NUM_MP*WARP_W-1:0] launch_warps,
   input logic [NUM_MP*BLK_W-1:0]  blk_occ,
   input logic [NUM_MP*THR_W-1:0]  thr_occ,
   input logic [NUM_MP*WARP_W-1:0] wrp_occ
);
   localparam int MAXW = MP_MAX_THREADS / WARP_SIZE;

   assert_one_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(launch_valid));

   assert_launch_follows_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|launch_valid) |-> $past(req_valid && req_ready && !req_error));

   assert_error_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_error |-> (req_threads == '0 || req_threads > THR_W'(MAX_BLK_THREADS)));

   assert_error_no_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_error |=> !(|launch_valid));

   assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> !(|launch_valid));

   for (genvar g = 0; g < NUM_MP; g++) begin : g_chk
      assert_warp_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
         launch_valid[g] |-> launch_warps[g*WARP_W +: WARP_W]
            == WARP_W'(tbd_pkg::ceil_div(32'($past(req_threads)), WARP_SIZE)));
      assert_block_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
         blk_occ[g*BLK_W +: BLK_W] <= BLK_W'(MP_MAX_BLOCKS));
      assert_thread_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
         thr_occ[g*THR_W +: THR_W] <= THR_W'(MP_MAX_THREADS));
      assert_warp_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
         wrp_occ[g*WARP_W +: WARP_W] <= WARP_W'(MAXW));
   end
endmodule

bind tbd_dispatch tbd_dispatch_chk #(
   .NUM_MP          (NUM_MP),
   .WARP_SIZE       (WARP_SIZE),
   .MAX_BLK_THREADS (MAX_BLK_THREADS),
   .MP_MAX_BLOCKS   (MP_MAX_BLOCKS),
   .MP_MAX_THREADS  (MP_MAX_THREADS),
   .THR_W           (THR_W),
   .WARP_W          (WARP_W),
   .BLK_W           (BLK_W)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_threads  (req_threads),
   .req_error    (req_error),
   .launch_valid (launch_valid),
   .launch_warps (launch_warps),
   .blk_occ      (blk_occ),
   .thr_occ      (thr_occ),
   .wrp_occ      (wrp_occ)
);

// File: tb/test_tbd_dispatch.sv
module test_tbd_dispatch;
   localparam int NMP = 2;
   localparam int IDW = 8;
   localparam int THW = 10;
   localparam int WW  = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n;
   logic              req_valid;
   logic              req_ready;
   logic [IDW-1:0]    req_id;
   logic [THW-1:0]    req_threads;
   logic              req_error;
   logic [NMP-1:0]    launch_valid;
   logic [NMP*IDW-1:0] launch_id;
   logic [NMP*WW-1:0] launch_warps;
   logic [NMP-1:0]    done_valid;
   logic [NMP*THW-1:0] done_threads;
   logic [NMP*WW-1:0] done_warps;

   tbd_dispatch #(.NUM_MP(NMP), .ID_W(IDW)) i_tbd_dispatch (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
      .req_threads(req_threads), .req_error(req_error),
      .launch_valid(launch_valid), .launch_id(launch_id), .launch_warps(launch_warps),
      .done_valid(done_valid), .done_threads(done_threads), .done_warps(done_warps)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int got_id, got_w;
   bit finished = 1'b0;

   task automatic chk(input string r, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", r, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req_valid = 1'b0; req_id = '0; req_threads = '0;
      done_valid = '0; done_threads = '0; done_warps = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic int launched_mp();
      int m = -1;
      for (int i = 0; i < NMP; i++)
         if (launch_valid[i]) begin
            m = i;
            got_id = int'(launch_id[i*IDW +: IDW]);
            got_w  = int'(launch_warps[i*WW +: WW]);
         end
      return m;
   endfunction

   task automatic push(input int id, input int thr, output int mp, output int err);
      int w = 0;
      @(negedge clk);
      req_valid = 1'b1; req_id = IDW'(id); req_threads = THW'(thr);
      #2;
      while (!req_ready && w < 40) begin @(negedge clk); #2; w++; end
      err = int'(req_error);
      @(negedge clk);
      req_valid = 1'b0;
      mp = launched_mp();
   endtask

   task automatic release_mp(input int mp, input int thr, input int w);
      @(negedge clk);
      done_valid[mp] = 1'b1;
      done_threads[mp*THW +: THW] = THW'(thr);
      done_warps[mp*WW +: WW] = WW'(w);
      @(negedge clk);
      done_valid = '0;
   endtask

   task automatic t_reset();
      int mp, err;
      do_reset();
      @(negedge clk);
      chk("R1 idle launch", int'(launch_valid), 0);
      push(7, 64, mp, err);
      chk("R1 first mp", mp, 0);
      chk("R1 first id", got_id, 7);
   endtask

   task automatic t_warps();
      int mp, err;
      int sizes[4] = '{1, 32, 33, 512};
      do_reset();
      foreach (sizes[k]) begin
         push(10 + k, sizes[k], mp, err);
         chk("R2 mp", mp, 0);
         chk("R2 warps", got_w, (sizes[k] + 31) / 32);
      end
      @(negedge clk);
      chk("R10 pulse ends", int'(launch_valid), 0);
   endtask

   task automatic t_invalid();
      int mp, err;
      do_reset();
      push(1, 0, mp, err);
      chk("R3 zero err", err, 1);
      chk("R3 zero no launch", mp, -1);
      push(2, 600, mp, err);
      chk("R3 600 err", err, 1);
      chk("R3 600 no launch", mp, -1);
      push(3, 513, mp, err);
      chk("R3 513 err", err, 1);
      chk("R3 513 no launch", mp, -1);
      push(4, 512, mp, err);
      chk("R3 512 legal", err, 0);
      chk("R3 512 mp", mp, 0);
      push(5, 256, mp, err);
      chk("R3 no occupancy taken", mp, 0);
   endtask

   task automatic t_blocks();
      int mp, err;
      do_reset();
      for (int k = 0; k < 8; k++) begin
         push(k, 1, mp, err);
         chk("R7 lowest mp", mp, 0);
      end
      push(8, 1, mp, err);
      chk("R4 ninth block", mp, 1);
   endtask

   task automatic t_threads();
      int mp, err;
      do_reset();
      push(1, 512, mp, err); chk("R5 a", mp, 0);
      push(2, 512, mp, err); chk("R5 b", mp, 1);
      push(3, 256, mp, err); chk("R5 c", mp, 0);
      push(4, 1, mp, err);   chk("R5 d", mp, 1);
   endtask

   task automatic t_warp_cap();
      int mp, err;
      do_reset();
      for (int k = 0; k < 6; k++) begin
         push(k, 97, mp, err);
         chk("R6 fill", mp, 0);
      end
      push(6, 97, mp, err);
      chk("R6 warp cap", mp, 1);
   endtask

   task automatic t_stall();
      int mp, err;
      do_reset();
      push(1, 512, mp, err);
      push(2, 512, mp, err);
      @(negedge clk);
      req_valid = 1'b1; req_id = 8'd3; req_threads = 10'd512;
      #2;
      chk("R8 ready low", int'(req_ready), 0);
      @(negedge clk);
      chk("R8 no launch", int'(launch_valid), 0);
      chk("R8 still low", int'(req_ready), 0);
      done_valid[1] = 1'b1;
      done_threads[THW +: THW] = 10'd512;
      done_warps[WW +: WW] = 5'd16;
      @(negedge clk);
      done_valid = '0;
      #2;
      chk("R9 freed ready", int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 launched mp1", int'(launch_valid), 2);
      chk("R9 launched id", int'(launch_id[IDW +: IDW]), 3);
   endtask

   task automatic t_same_cycle();
      int mp, err;
      do_reset();
      for (int k = 0; k < 7; k++) push(k, 1, mp, err);
      @(negedge clk);
      req_valid = 1'b1; req_id = 8'd20; req_threads = 10'd1;
      done_valid[0] = 1'b1;
      done_threads[0 +: THW] = 10'd1;
      done_warps[0 +: WW] = 5'd1;
      #2;
      chk("R9 sim ready", int'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0; done_valid = '0;
      chk("R9 sim launch", int'(launch_valid), 1);
      push(21, 1, mp, err);
      chk("R9 both applied a", mp, 0);
      push(22, 1, mp, err);
      chk("R9 both applied b", mp, 1);
   endtask

   initial begin
      t_reset();
      t_warps();
      t_invalid();
      t_blocks();
      t_threads();
      t_warp_cap();
      t_stall();
      t_same_cycle();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule